// File: doc/BRIEF.md
# Dual Timer/Counter with Clock-Source Selection

This block holds two 16-bit timer/counters in the classic 8051 arrangement. Each has four operating modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a split mode. Software sets them up through a small byte-wide register port. A mode register holds the gate enable, the pin-count select and the mode field of each timer. A control register holds the run bits and the overflow flags. A source register holds a two-bit input selector for each timer.

Each timer picks one of four count sources. The first two are internal tick enables from prescalers that sit outside the block. The third is falling edges on the timer's own count pin. The fourth is a CPU-activity source: Timer 0 takes one step per instruction completed, and Timer 1 takes as many steps as the ROM bytes fetched in that cycle. The count and gate pins pass through a synchronizer first. The overflow flags go to the interrupt logic, which clears them with an acknowledge strobe.

Top module: `tmr_pair_ctl`

## Requirements
- R1: After reset every register reads zero, both flags are low, and both timers count source 0 (tick_a).
- R2: Register addresses are: 0 = mode, 1 = control, 2 = source, 3 = TL0, 4 = TH0, 5 = TL1, 6 = TH1. Control reads {4'b0, flag1, flag0, run1, run0}. The source register keeps only bits 7:4, and its low nibble reads 0.
- R3: The source selector is bits 5:4 for Timer 0 and bits 7:6 for Timer 1. The codes are 0 = tick_a, 1 = tick_b, 2 = count pin, 3 = CPU activity. A source that is not selected has no effect.
- R4: A synchronized falling edge on a timer's count pin adds one to that timer. This happens when its pin-count bit is 1 (mode bit 6 for Timer 1, bit 2 for Timer 0), or when its selector is 2. The count lands three clock edges after the pin falls, and there is at most one step per cycle.
- R5: With selector 3, Timer 0 adds 1 for each cycle with instr_done high, and Timer 1 adds fetch_bytes (0 to 3) each cycle.
- R6: A timer advances only while its run bit is 1. When its gate bit is 1 (mode bit 7 for Timer 1, bit 3 for Timer 0), its synchronized gate pin must also be high.
- R7: Mode 0 (mode field 00; bits 5:4 for Timer 1, bits 1:0 for Timer 0) counts {TH, TL[4:0]} as 13 bits. TL[7:5] keep their written value, and a carry out of bit 12 sets the flag.
- R8: Mode 1 counts {TH, TL} as 16 bits, and a wrap from 0xFFFF sets the flag.
- R9: Mode 2 counts TL. On a carry out it sets the flag and loads TL from TH. TH never changes.
- R10: In mode 3, Timer 1 holds its value. Timer 0 in mode 3 splits in two. TL0 follows Timer 0's run, gate and pin-count settings and sets flag0. TH0 counts Timer 0's selected source with pin-count forced off, runs on run1, and sets flag1.
- R11: While Timer 0 is in mode 3, Timer 1 in modes 0 to 2 counts without regard to run1 and never sets flag1.
- R12: A write to TL or TH of a timer in the same cycle as a count step drops that timer's step. The written byte takes the written value.
- R13: A control write loads both flags from bits 3:2. An acknowledge clears its flag, but an overflow in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational register readback |
| cnt0_pin | input | 1 | Timer 0 count pin (asynchronous) |
| cnt1_pin | input | 1 | Timer 1 count pin (asynchronous) |
| gate0_pin | input | 1 | Timer 0 gate pin (asynchronous) |
| gate1_pin | input | 1 | Timer 1 gate pin (asynchronous) |
| tick_a | input | 1 | First internal prescaled tick enable |
| tick_b | input | 1 | Second internal prescaled tick enable |
| fetch_bytes | input | 2 | ROM bytes fetched this cycle |
| instr_done | input | 1 | One instruction completed this cycle |
| flag0_ack | input | 1 | Interrupt acknowledge for flag0 |
| flag1_ack | input | 1 | Interrupt acknowledge for flag1 |
| ovf0_flag | output | 1 | Timer 0 overflow flag |
| ovf1_flag | output | 1 | Timer 1 overflow flag |

## Verification
Two pairs of events can meet in one cycle. The first is a software write to a count byte and a count step. The bench raises the selected tick in the same cycle as a TL0 write and expects the written byte to stand with no step added. The second is an overflow and an acknowledge of the same flag. The bench rolls Timer 0 over from 0xFFFF in the cycle it pulses the acknowledge, and expects the flag to read set afterwards. A later control write is then expected to clear it.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int DW     = 8;
    localparam int LOW_W  = 5;
    localparam int INC_W  = 2;
    localparam int AW     = 3;

    typedef enum logic [1:0] {SRC_TICK_A, SRC_TICK_B, SRC_PIN, SRC_CPU} src_e;
    typedef enum logic [1:0] {MD_13, MD_16, MD_RELOAD, MD_SPLIT} mode_e;

    localparam logic [AW-1:0] A_MODE = 3'd0;
    localparam logic [AW-1:0] A_CTRL = 3'd1;
    localparam logic [AW-1:0] A_SRC  = 3'd2;
    localparam logic [AW-1:0] A_TL0  = 3'd3;
    localparam logic [AW-1:0] A_TH0  = 3'd4;
    localparam logic [AW-1:0] A_TL1  = 3'd5;
    localparam logic [AW-1:0] A_TH1  = 3'd6;

    typedef struct packed {
        logic [DW-1:0] mode_r;
        logic [DW-1:0] src_r;
        logic [DW-1:0] tl0;
        logic [DW-1:0] th0;
        logic [DW-1:0] tl1;
        logic [DW-1:0] th1;
        logic          run0;
        logic          run1;
        logic          flag0;
        logic          flag1;
    } regs_t;
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

    // R4: a detected edge lasts a single cycle
    assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_src_sel.sv
`timescale 1ns/1ps
module tmr_src_sel #(
    parameter int INC_W = 2
) (
    input  logic [1:0]       sel,
    input  logic             pin_force,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             pin_fall,
    input  logic [INC_W-1:0] cpu_amt,
    output logic [INC_W-1:0] inc_o
);
    import tmr_pkg::*;

    always_comb begin
        inc_o = '0;
        if (pin_force) begin
            inc_o = INC_W'(pin_fall);
        end else begin
            case (src_e'(sel))
                SRC_TICK_A: inc_o = INC_W'(tick_a);
                SRC_TICK_B: inc_o = INC_W'(tick_b);
                SRC_PIN:    inc_o = INC_W'(pin_fall);
                default:    inc_o = cpu_amt;
            endcase
        end
    end
endmodule

// File: rtl/tmr_count_unit.sv
`timescale 1ns/1ps
module tmr_count_unit #(
    parameter int DW    = 8,
    parameter int LOW_W = 5,
    parameter int INC_W = 2
) (
    input  logic [1:0]       mode,
    input  logic             en,
    input  logic [DW-1:0]    tl_i,
    input  logic [DW-1:0]    th_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [DW-1:0]    tl_o,
    output logic [DW-1:0]    th_o,
    output logic             carry_o
);
    import tmr_pkg::*;

    localparam int NARROW_W = DW + LOW_W;
    localparam int WIDE_W   = 2 * DW;

    logic [NARROW_W:0] sum_narrow;
    logic [WIDE_W:0]   sum_wide;
    logic [DW:0]       sum_low;

    assign sum_narrow = {1'b0, th_i, tl_i[LOW_W-1:0]} + (NARROW_W+1)'(inc_i);
    assign sum_wide   = {1'b0, th_i, tl_i} + (WIDE_W+1)'(inc_i);
    assign sum_low    = {1'b0, tl_i} + (DW+1)'(inc_i);

    always_comb begin
        tl_o    = tl_i;
        th_o    = th_i;
        carry_o = 1'b0;
        if (en) begin
            case (mode_e'(mode))
                MD_13: begin
                    tl_o    = {tl_i[DW-1:LOW_W], sum_narrow[LOW_W-1:0]};
                    th_o    = sum_narrow[NARROW_W-1:LOW_W];
                    carry_o = sum_narrow[NARROW_W];
                end
                MD_16: begin
                    tl_o    = sum_wide[DW-1:0];
                    th_o    = sum_wide[WIDE_W-1:DW];
                    carry_o = sum_wide[WIDE_W];
                end
                MD_RELOAD: begin
                    tl_o    = sum_low[DW] ? th_i : sum_low[DW-1:0];
                    carry_o = sum_low[DW];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_pair_ctl.sv
`timescale 1ns/1ps
module tmr_pair_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        cnt0_pin,
    input  logic        cnt1_pin,
    input  logic        gate0_pin,
    input  logic        gate1_pin,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic [1:0]  fetch_bytes,
    input  logic        instr_done,
    input  logic        flag0_ack,
    input  logic        flag1_ack,
    output logic        ovf0_flag,
    output logic        ovf1_flag
);
    import tmr_pkg::*;

    localparam int NPIN = 4;

    regs_t st_d, st_q;

    // ---------------- pin synchronizers ----------------
    logic [NPIN-1:0] pin_raw, pin_lvl, pin_fall;
    assign pin_raw = {gate1_pin, gate0_pin, cnt1_pin, cnt0_pin};

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_sync
        tmr_pin_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL ((gi < 2) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_raw[gi]),
            .level_o (pin_lvl[gi]),
            .fall_o  (pin_fall[gi])
        );
    end

    // ---------------- field decode ----------------
    logic       gate_en0, gate_en1, pin_cnt0, pin_cnt1;
    logic [1:0] mode0, mode1, sel0, sel1;
    logic       split;

    assign gate_en1 = st_q.mode_r[7];
    assign pin_cnt1 = st_q.mode_r[6];
    assign mode1    = st_q.mode_r[5:4];
    assign gate_en0 = st_q.mode_r[3];
    assign pin_cnt0 = st_q.mode_r[2];
    assign mode0    = st_q.mode_r[1:0];
    assign sel1     = st_q.src_r[7:6];
    assign sel0     = st_q.src_r[5:4];
    assign split    = (mode0 == MD_SPLIT);

    logic cnt0_wr, cnt1_wr, ctrl_wr;
    assign cnt0_wr = wr_en && ((wr_addr == A_TL0) || (wr_addr == A_TH0));
    assign cnt1_wr = wr_en && ((wr_addr == A_TL1) || (wr_addr == A_TH1));
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    logic go0, go1;
    assign go0 = st_q.run0 & (~gate_en0 | pin_lvl[2]);
    assign go1 = st_q.run1 & (~gate_en1 | pin_lvl[3]);

    // ---------------- source selection ----------------
    logic [INC_W-1:0] inc0, inc0_hi, inc1;

    tmr_src_sel #(.INC_W(INC_W)) u_src0 (
        .sel       (sel0),
        .pin_force (pin_cnt0),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pin_fall  (pin_fall[0]),
        .cpu_amt   (INC_W'(instr_done)),
        .inc_o     (inc0)
    );

    tmr_src_sel #(.INC_W(INC_W)) u_src0_hi (
        .sel       (sel0),
        .pin_force (1'b0),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pin_fall  (pin_fall[0]),
        .cpu_amt   (INC_W'(instr_done)),
        .inc_o     (inc0_hi)
    );

    tmr_src_sel #(.INC_W(INC_W)) u_src1 (
        .sel       (sel1),
        .pin_force (pin_cnt1),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .pin_fall  (pin_fall[1]),
        .cpu_amt   (fetch_bytes),
        .inc_o     (inc1)
    );

    // ---------------- counting units ----------------
    logic          en0, en1, c0, c1;
    logic [DW-1:0] u0_tl, u0_th, u1_tl, u1_th;

    assign en0 = go0 & ~cnt0_wr & ~split;
    assign en1 = ~cnt1_wr & (mode1 != MD_SPLIT) & (split | go1);

    tmr_count_unit #(.DW(DW), .LOW_W(LOW_W), .INC_W(INC_W)) u_cnt0 (
        .mode    (mode0),
        .en      (en0),
        .tl_i    (st_q.tl0),
        .th_i    (st_q.th0),
        .inc_i   (inc0),
        .tl_o    (u0_tl),
        .th_o    (u0_th),
        .carry_o (c0)
    );

    tmr_count_unit #(.DW(DW), .LOW_W(LOW_W), .INC_W(INC_W)) u_cnt1 (
        .mode    (mode1),
        .en      (en1),
        .tl_i    (st_q.tl1),
        .th_i    (st_q.th1),
        .inc_i   (inc1),
        .tl_o    (u1_tl),
        .th_o    (u1_th),
        .carry_o (c1)
    );

    // split-mode halves of Timer 0
    logic [DW:0] half_lo, half_hi;
    assign half_lo = {1'b0, st_q.tl0} + (DW+1)'(inc0);
    assign half_hi = {1'b0, st_q.th0} + (DW+1)'(inc0_hi);

    // ---------------- next state ----------------
    logic set0, set1;

    always_comb begin
        st_d = st_q;
        set0 = 1'b0;
        set1 = 1'b0;

        if (!split) begin
            st_d.tl0 = u0_tl;
            st_d.th0 = u0_th;
            set0     = c0;
        end else begin
            if (go0 && !cnt0_wr) begin
                st_d.tl0 = half_lo[DW-1:0];
                set0     = half_lo[DW];
            end
            if (st_q.run1 && !cnt0_wr) begin
                st_d.th0 = half_hi[DW-1:0];
                set1     = half_hi[DW];
            end
        end

        st_d.tl1 = u1_tl;
        st_d.th1 = u1_th;
        if (!split) set1 = c1;

        st_d.flag0 = set0 | (st_q.flag0 & ~flag0_ack);
        st_d.flag1 = set1 | (st_q.flag1 & ~flag1_ack);

        if (wr_en) begin
            case (wr_addr)
                A_MODE: st_d.mode_r = wr_data;
                A_CTRL: begin
                    st_d.run0  = wr_data[0];
                    st_d.run1  = wr_data[1];
                    st_d.flag0 = wr_data[2];
                    st_d.flag1 = wr_data[3];
                end
                A_SRC:  st_d.src_r = {wr_data[7:4], 4'b0000};
                A_TL0:  st_d.tl0 = wr_data;
                A_TH0:  st_d.th0 = wr_data;
                A_TL1:  st_d.tl1 = wr_data;
                A_TH1:  st_d.th1 = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- readback ----------------
    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = st_q.mode_r;
            A_CTRL:  rd_data = {4'b0000, st_q.flag1, st_q.flag0, st_q.run1, st_q.run0};
            A_SRC:   rd_data = st_q.src_r;
            A_TL0:   rd_data = st_q.tl0;
            A_TH0:   rd_data = st_q.th0;
            A_TL1:   rd_data = st_q.tl1;
            A_TH1:   rd_data = st_q.th1;
            default: rd_data = '0;
        endcase
    end

    assign ovf0_flag = st_q.flag0;
    assign ovf1_flag = st_q.flag1;

    // ---------------- assertions ----------------
    assert_wr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TL0) |=> (st_q.tl0 == $past(wr_data)));

    assert_ack_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (flag0_ack && !ctrl_wr && !set0) |=> !ovf0_flag);

    assert_reload_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == MD_RELOAD && !(wr_en && wr_addr == A_TH1)) |=> $stable(st_q.th1));

    assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run0 && !split && !cnt0_wr) |=> ($stable(st_q.tl0) && $stable(st_q.th0)));

    assert_t1_split_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == MD_SPLIT && !cnt1_wr) |=> ($stable(st_q.tl1) && $stable(st_q.th1)));
endmodule

// File: tb/tmr_pair_ctl_tb.sv
`timescale 1ns/1ps
module tmr_pair_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt0_pin = 1'b1, cnt1_pin = 1'b1;
    logic       gate0_pin = 1'b0, gate1_pin = 1'b0;
    logic       tick_a = 1'b0, tick_b = 1'b0;
    logic [1:0] fetch_bytes = '0;
    logic       instr_done = 1'b0;
    logic       flag0_ack = 1'b0, flag1_ack = 1'b0;
    logic       ovf0_flag, ovf1_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tmr_pair_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt0_pin(cnt0_pin), .cnt1_pin(cnt1_pin),
        .gate0_pin(gate0_pin), .gate1_pin(gate1_pin), .tick_a(tick_a), .tick_b(tick_b),
        .fetch_bytes(fetch_bytes), .instr_done(instr_done), .flag0_ack(flag0_ack),
        .flag1_ack(flag1_ack), .ovf0_flag(ovf0_flag), .ovf1_flag(ovf1_flag)
    );

    // monitor: pops expected items and compares readback
    initial begin
        forever begin
            @(posedge clk);
            #0.5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #0.5;
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string tag);
        item_t it;
        it.addr = a; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_a(input int n);
        tick_a = 1'b1;
        repeat (n) @(negedge clk);
        tick_a = 1'b0;
    endtask

    task automatic pulse_b(input int n);
        tick_b = 1'b1;
        repeat (n) @(negedge clk);
        tick_b = 1'b0;
    endtask

    task automatic pin0_edge();
        cnt0_pin = 1'b0;
        repeat (3) @(negedge clk);
        cnt0_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg(3'd0, 8'h00, "R1 mode");
        expect_reg(3'd1, 8'h00, "R1 ctrl");
        expect_reg(3'd3, 8'h00, "R1 TL0");
        expect_reg(3'd6, 8'h00, "R1 TH1");

        // R2 source register keeps only upper nibble
        wr(3'd2, 8'hFF);
        expect_reg(3'd2, 8'hF0, "R2 src readback");
        wr(3'd2, 8'h00);

        // R3 / R8 mode 1, tick_a selected, tick_b ignored
        wr(3'd0, 8'h11);
        wr(3'd1, 8'h01);
        pulse_a(5);
        pulse_b(3);
        expect_reg(3'd3, 8'h05, "R3 tick_a count");
        wr(3'd2, 8'h10);
        pulse_b(3);
        pulse_a(2);
        expect_reg(3'd3, 8'h08, "R3 tick_b count");

        // R6 stopped and gated
        wr(3'd1, 8'h00);
        pulse_b(4);
        expect_reg(3'd3, 8'h08, "R6 stopped");
        wr(3'd0, 8'h19);
        wr(3'd1, 8'h01);
        pulse_b(3);
        expect_reg(3'd3, 8'h08, "R6 gate low");
        gate0_pin = 1'b1;
        repeat (3) @(negedge clk);
        pulse_b(2);
        expect_reg(3'd3, 8'h0A, "R6 gate high");

        // R12 write beats a step in the same cycle
        tick_b = 1'b1;
        wr(3'd3, 8'h40);
        tick_b = 1'b0;
        expect_reg(3'd3, 8'h40, "R12 TL0 written");
        expect_reg(3'd4, 8'h00, "R12 TH0 held");

        // R8 16-bit wrap
        wr(3'd3, 8'hFE);
        wr(3'd4, 8'hFF);
        pulse_b(2);
        expect_reg(3'd3, 8'h00, "R8 TL0 wrap");
        expect_reg(3'd1, 8'h05, "R8 flag0 set");

        // R13 ack, ack racing overflow, control write clear
        flag0_ack = 1'b1;
        @(negedge clk);
        flag0_ack = 1'b0;
        expect_reg(3'd1, 8'h01, "R13 ack clears");
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        tick_b = 1'b1; flag0_ack = 1'b1;
        @(negedge clk);
        tick_b = 1'b0; flag0_ack = 1'b0;
        expect_reg(3'd1, 8'h05, "R13 overflow beats ack");
        wr(3'd1, 8'h01);
        expect_reg(3'd1, 8'h01, "R13 ctrl write clears");

        // R7 mode 0 on Timer 1
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h00);
        wr(3'd6, 8'hFF);
        wr(3'd5, 8'hFE);
        pulse_a(2);
        expect_reg(3'd5, 8'hE0, "R7 TL1 high bits kept");
        expect_reg(3'd6, 8'h00, "R7 TH1 wrap");
        expect_reg(3'd1, 8'h0A, "R7 flag1 set");

        // R9 mode 2 reload
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h20);
        wr(3'd6, 8'h80);
        wr(3'd5, 8'hFE);
        pulse_a(3);
        expect_reg(3'd5, 8'h81, "R9 TL1 reloaded");
        expect_reg(3'd6, 8'h80, "R9 TH1 unchanged");
        expect_reg(3'd1, 8'h0A, "R9 flag1 set");

        // R5 CPU-activity sources
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h10);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h00);
        wr(3'd2, 8'hD0);
        fetch_bytes = 2'd3; @(negedge clk);
        fetch_bytes = 2'd2; @(negedge clk);
        fetch_bytes = 2'd0; @(negedge clk);
        fetch_bytes = 2'd1; @(negedge clk);
        fetch_bytes = 2'd0;
        expect_reg(3'd5, 8'h06, "R5 fetched bytes");
        wr(3'd2, 8'hF0);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h11);
        wr(3'd3, 8'h00);
        instr_done = 1'b1;
        repeat (4) @(negedge clk);
        instr_done = 1'b0;
        expect_reg(3'd3, 8'h04, "R5 instructions");

        // R4 pin counting via selector and via pin-count bit
        wr(3'd2, 8'h20);
        wr(3'd3, 8'h00);
        for (int k = 0; k < 3; k++) pin0_edge();
        expect_reg(3'd3, 8'h03, "R4 pin via selector");
        wr(3'd2, 8'h00);
        wr(3'd0, 8'h15);
        pulse_a(2);
        pin0_edge();
        pin0_edge();
        expect_reg(3'd3, 8'h05, "R4 pin via count bit");

        // R10 / R11 split mode
        wr(3'd0, 8'h13);
        wr(3'd3, 8'hFE);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        wr(3'd1, 8'h01);
        pulse_a(2);
        expect_reg(3'd3, 8'h00, "R10 TL0 half");
        expect_reg(3'd4, 8'hFF, "R10 TH0 stopped by run1");
        expect_reg(3'd5, 8'h01, "R11 timer1 free running");
        expect_reg(3'd1, 8'h05, "R11 no flag1 from timer1");
        wr(3'd1, 8'h02);
        pulse_a(1);
        expect_reg(3'd4, 8'h00, "R10 TH0 wrap");
        expect_reg(3'd3, 8'h00, "R10 TL0 stopped");
        expect_reg(3'd1, 8'h0A, "R10 TH0 sets flag1");
        wr(3'd0, 8'h31);
        pulse_a(3);
        expect_reg(3'd5, 8'h02, "R10 timer1 mode3 holds");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule